// File: doc/BRIEF.md
# I2C Register-Access Master

This block performs whole register transactions on a two-wire I2C bus against a single target whose 7-bit address is a parameter (default 0x68, giving 0xD0 and 0xD1 as the write and read address bytes). The user supplies a register index, a direction and, for a write, a data byte, then pulses `go`. The controller builds the complete bus sequence on its own. A write is START, write address, index, data, STOP. A read sends the write address and index, then a repeated START with no STOP before it, the read address, one received byte answered with a not-acknowledge, and STOP.

Both lines are open-drain. The block only ever pulls a line low through an output enable, and it reads SDA back for acknowledge bits and read data. SCL comes from the system clock. Each SCL bit is split into four quarters of `QUARTER_CYCLES` clocks. SDA moves only in a low quarter, except when it forms a START or a STOP. If the target fails to acknowledge any byte the master sent, the transaction ends early with a STOP and the error flag is raised.

Top module: `regbus_i2c_master`

## Requirements
- R1: After reset and whenever idle, `scl_oe`, `sda_oe`, `busy` and `done` are 0 (both lines released). `nack_err` is 0 after reset.
- R2: One SCL period is 4*`QUARTER_CYCLES` clocks. While SCL is high, SDA changes only to form START (SDA falls) or STOP (SDA rises).
- R3: A write (`rd_nwr`=0) puts START, 0xD0, the index, the data byte, and STOP on the bus. Bytes go MSB first, with a ninth clock in which the master releases SDA for the acknowledge.
- R4: A read (`rd_nwr`=1) sends START, 0xD0, the index, a repeated START with no STOP between, and 0xD1. It then clocks in eight bits MSB first into `rd_data`, leaves SDA released on the ninth clock (not-acknowledge), and sends STOP.
- R5: SDA high in the acknowledge slot of any byte the master sent ends the transaction with a STOP, with no further byte sent. `nack_err` is 1 together with `done`. `nack_err` holds that value until the next accepted `go`.
- R6: `busy` rises on the cycle after `go` is accepted. `done` is a single-cycle pulse on the cycle `busy` falls.
- R7: `go` is ignored while `busy`. The command in progress is unchanged and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe, accepted only when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| reg_addr | input | 8 | Register index sent to the target |
| wr_data | input | 8 | Byte written on a write |
| rd_data | output | 8 | Byte fetched by the last successful read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nack_err | output | 1 | Last transaction was aborted on a missing acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled level of the SDA line |

## Verification
The checker assumes that `go` and its command fields are driven synchronously to `clk`. It also assumes that SCL is never held low by another agent, because the master does not watch SCL. The bench drives every input on the falling clock edge. It models the bus as wired-AND with pull-ups and a target that only releases or pulls SDA on SCL edges, so the target never stretches the clock. Missing acknowledges are injected one byte position at a time, and `go` is pulsed mid-transfer only with new command values, so the command stability properties see a real attempt to disturb them.

// File: rtl/regbus_i2c_pkg.sv
`timescale 1ns/1ps
package regbus_i2c_pkg;
   localparam int unsigned OCTET = 8;
   localparam int unsigned CMD_W = 1 + 2 * OCTET;

   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_RESTART, PH_SHIFT, PH_STOP
   } phase_t;

   typedef enum logic [2:0] {
      BK_ADDR_W, BK_INDEX, BK_PAYLOAD, BK_ADDR_R, BK_FETCH
   } octet_t;
endpackage

// File: rtl/regbus_i2c_tick.sv
`timescale 1ns/1ps
module regbus_i2c_tick #(
   parameter int unsigned QUARTER_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (QUARTER_CYCLES < 2) begin : g_bad
         $error("regbus_i2c_tick: QUARTER_CYCLES must be 2 or more");
         assign tick = 1'b0;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(QUARTER_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (!run || cnt_q == LAST) cnt_q <= '0;
            else                          cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/regbus_i2c_shreg.sv
`timescale 1ns/1ps
module regbus_i2c_shreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         sin,
   output logic         msb,
   output logic [W-1:0] value
);
   generate
      if (W < 2) begin : g_bad
         $error("regbus_i2c_shreg: W must be 2 or more");
      end
   endgenerate

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (load)  sr_q <= load_val;
      else if (shift) sr_q <= {sr_q[W-2:0], sin};
   end

   assign msb   = sr_q[W-1];
   assign value = sr_q;
endmodule

// File: rtl/regbus_i2c_master.sv
`timescale 1ns/1ps
module regbus_i2c_master
   import regbus_i2c_pkg::*;
#(
   parameter int unsigned QUARTER_CYCLES = 4,
   parameter logic [6:0]  TARGET_ADDR    = 7'h68
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             rd_nwr,
   input  logic [OCTET-1:0] reg_addr,
   input  logic [OCTET-1:0] wr_data,
   output logic [OCTET-1:0] rd_data,
   output logic             busy,
   output logic             done,
   output logic             nack_err,
   output logic             scl_oe,
   output logic             sda_oe,
   input  logic             sda_i
);
   localparam logic [3:0] ACK_SLOT = 4'(OCTET);

   phase_t           ph_q, ph_d;
   octet_t           kind_q, kind_d;
   logic [1:0]       qtr_q, qtr_d;
   logic [3:0]       bit_q, bit_d;
   logic             abort_q, abort_d;
   logic             samp_q, err_q, done_q;
   logic             cmd_rd_q;
   logic [OCTET-1:0] idx_q, dat_q, rd_q;
   logic             tick, load, shift, fin, grab;
   logic [OCTET-1:0] load_val, sh_val;
   logic             sh_msb;
   logic             scl_lo, sda_lo, tx_low;
   logic             accept;
   logic             framing;
   logic [CMD_W-1:0] cmd_snap;

   assign accept = go && (ph_q == PH_IDLE);
   assign busy   = (ph_q != PH_IDLE);

   regbus_i2c_tick #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   regbus_i2c_shreg #(.W(OCTET)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .shift(shift), .sin(samp_q), .msb(sh_msb), .value(sh_val)
   );

   // sequencer: advances one quarter per tick, bytes end after the ack slot
   always_comb begin
      ph_d = ph_q;  kind_d = kind_q;  qtr_d = qtr_q;  bit_d = bit_q;
      abort_d = abort_q;  load = 1'b0;  shift = 1'b0;  fin = 1'b0;  grab = 1'b0;
      if (accept) begin
         ph_d = PH_START;  kind_d = BK_ADDR_W;  qtr_d = 2'd0;  abort_d = 1'b0;
      end else if (tick) begin
         qtr_d = qtr_q + 2'd1;
         if (qtr_q == 2'd3) begin
            unique case (ph_q)
               PH_START, PH_RESTART: begin
                  ph_d = PH_SHIFT;  bit_d = '0;  load = 1'b1;
               end
               PH_SHIFT: begin
                  if (bit_q != ACK_SLOT) begin
                     bit_d = bit_q + 4'd1;  shift = 1'b1;
                  end else begin
                     bit_d = '0;
                     if (kind_q != BK_FETCH && samp_q) begin
                        abort_d = 1'b1;  ph_d = PH_STOP;
                     end else begin
                        case (kind_q)
                           BK_ADDR_W:  begin kind_d = BK_INDEX; load = 1'b1; end
                           BK_INDEX:   if (cmd_rd_q) begin
                                          kind_d = BK_ADDR_R;  ph_d = PH_RESTART;
                                       end else begin
                                          kind_d = BK_PAYLOAD; load = 1'b1;
                                       end
                           BK_PAYLOAD: ph_d = PH_STOP;
                           BK_ADDR_R:  begin kind_d = BK_FETCH; load = 1'b1; end
                           default:    begin grab = 1'b1; ph_d = PH_STOP; end
                        endcase
                     end
                  end
               end
               PH_STOP: begin ph_d = PH_IDLE;  fin = 1'b1; end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (kind_d)
         BK_ADDR_W:  load_val = {TARGET_ADDR, 1'b0};
         BK_INDEX:   load_val = idx_q;
         BK_PAYLOAD: load_val = dat_q;
         BK_ADDR_R:  load_val = {TARGET_ADDR, 1'b1};
         default:    load_val = '1;
      endcase
   end

   // line levels per phase and quarter; 1 means pull low
   assign tx_low = (bit_q != ACK_SLOT) && (kind_q != BK_FETCH) && !sh_msb;

   always_comb begin
      scl_lo = 1'b0;  sda_lo = 1'b0;
      unique case (ph_q)
         PH_START:   begin scl_lo = (qtr_q == 2'd3);                  sda_lo = (qtr_q != 2'd0); end
         PH_RESTART: begin scl_lo = (qtr_q == 2'd0) || (qtr_q == 2'd3); sda_lo = qtr_q[1];       end
         PH_SHIFT:   begin scl_lo = (qtr_q == 2'd0) || (qtr_q == 2'd3); sda_lo = tx_low;         end
         PH_STOP:    begin scl_lo = (qtr_q == 2'd0);                  sda_lo = !qtr_q[1];       end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;  kind_q <= BK_ADDR_W;  qtr_q <= '0;  bit_q <= '0;
         abort_q <= 1'b0;  samp_q <= 1'b1;  err_q <= 1'b0;  done_q <= 1'b0;
         cmd_rd_q <= 1'b0;  idx_q <= '0;  dat_q <= '0;  rd_q <= '0;
         scl_oe <= 1'b0;  sda_oe <= 1'b0;
      end else begin
         ph_q <= ph_d;  kind_q <= kind_d;  qtr_q <= qtr_d;  bit_q <= bit_d;
         abort_q <= abort_d;
         done_q  <= fin;
         scl_oe  <= scl_lo;
         sda_oe  <= sda_lo;
         if (tick && qtr_q == 2'd2 && ph_q == PH_SHIFT) samp_q <= sda_i;
         if (accept) begin
            cmd_rd_q <= rd_nwr;  idx_q <= reg_addr;  dat_q <= wr_data;  err_q <= 1'b0;
         end else if (fin) begin
            err_q <= abort_q;
         end
         if (grab) rd_q <= sh_val;
      end
   end

   assign done     = done_q;
   assign nack_err = err_q;
   assign rd_data  = rd_q;
   assign framing  = (ph_q == PH_START) || (ph_q == PH_RESTART) || (ph_q == PH_STOP);
   assign cmd_snap = {cmd_rd_q, idx_q, dat_q};
endmodule

// File: rtl/regbus_i2c_master_chk.sv
`timescale 1ns/1ps
module regbus_i2c_master_chk
   import regbus_i2c_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic             busy,
   input logic             done,
   input logic             nack_err,
   input logic             scl_oe,
   input logic             sda_oe,
   input logic             framing,
   input logic [CMD_W-1:0] cmd_snap
);
   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   assert_sda_still_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> framing);

   assert_err_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(nack_err));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_go_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go) |=> $stable(cmd_snap));

   assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cmd_snap));
endmodule

bind regbus_i2c_master regbus_i2c_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
   .nack_err(nack_err), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .framing(framing), .cmd_snap(cmd_snap)
);

// File: tb/regbus_i2c_master_tb_top.sv
`timescale 1ns/1ps
module regbus_i2c_master_tb_top;
   localparam int QC = 4;
   localparam int NONE = 7;
   localparam int NV = 13;
   // {rd_nwr, index, data, nack position (7 = none)}
   localparam logic [19:0] VEC [NV] = '{
      {1'b0, 8'h10, 8'hA5, 3'd7}, {1'b1, 8'h10, 8'h00, 3'd7},
      {1'b0, 8'hFF, 8'h00, 3'd7}, {1'b1, 8'hFF, 8'h00, 3'd7},
      {1'b0, 8'h00, 8'hFF, 3'd7}, {1'b1, 8'h00, 8'h00, 3'd7},
      {1'b1, 8'h42, 8'h00, 3'd7}, {1'b0, 8'h20, 8'h3C, 3'd0},
      {1'b0, 8'h20, 8'h3C, 3'd1}, {1'b0, 8'h20, 8'h3C, 3'd2},
      {1'b1, 8'h20, 8'h00, 3'd7}, {1'b1, 8'h21, 8'h00, 3'd2},
      {1'b1, 8'h33, 8'h00, 3'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0, rd_nwr = 1'b0;
   logic [7:0] reg_addr = '0, wr_data = '0;
   logic [7:0] rd_data;
   logic busy, done, nack_err, scl_oe, sda_oe;
   logic tgt_pull = 1'b0;
   wire  scl_bus = !scl_oe;
   wire  sda_bus = !(sda_oe || tgt_pull);

   int n_chk = 0, n_bad = 0;
   int cyc = 0, rise_last = 0, rise_prev = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge scl_bus) begin rise_prev = rise_last; rise_last = cyc; end

   regbus_i2c_master #(.QUARTER_CYCLES(QC)) dut_i (
      .clk(clk), .rst_n(rst_n), .go(go), .rd_nwr(rd_nwr), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
      .nack_err(nack_err), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus)
   );

   // target model
   logic [7:0] tmem [256];
   logic [7:0] smem [256];
   logic [7:0] tlog [256];
   int   t_n = 0, starts = 0, stops = 0, nack_abs = -1;
   int   t_cnt = 0, t_bidx = 0;
   logic t_act = 0, t_send = 0, t_pend = 0, t_mack = 0, t_ok;
   logic p_scl = 1, p_sda = 1;
   logic [7:0] t_sh = 0, t_tx = 0, t_ptr = 0;

   initial for (int i = 0; i < 256; i++) begin
      tmem[i] = 8'(i * 13 + 5);
      smem[i] = 8'(i * 13 + 5);
   end

   always @(scl_bus or sda_bus) begin
      if (scl_bus && !p_scl) begin
         if (t_act) begin
            if (t_cnt < 8) t_sh = {t_sh[6:0], sda_bus};
            else if (t_send) t_mack = sda_bus;
            t_cnt = t_cnt + 1;
         end
      end else if (!scl_bus && p_scl) begin
         if (t_act) begin
            if (t_cnt == 8) begin
               if (t_send) tgt_pull = 1'b0;
               else begin
                  t_ok = (t_n != nack_abs);
                  tlog[t_n[7:0]] = t_sh;  t_n = t_n + 1;
                  if (t_bidx == 0) begin
                     if (t_sh[7:1] != 7'h68) t_ok = 1'b0;
                     if (t_ok && t_sh[0]) t_pend = 1'b1;
                  end else if (t_bidx == 1) begin
                     if (t_ok) t_ptr = t_sh;
                  end else if (t_ok) begin
                     tmem[t_ptr] = t_sh;  t_ptr = t_ptr + 8'd1;
                  end
                  tgt_pull = t_ok;
               end
            end else if (t_cnt == 9) begin
               tgt_pull = 1'b0;  t_cnt = 0;  t_bidx = t_bidx + 1;
               if (t_send) t_send = 1'b0;
               else if (t_pend) begin
                  t_pend = 1'b0;  t_send = 1'b1;  t_tx = tmem[t_ptr];  tgt_pull = !t_tx[7];
               end
            end else if (t_send && t_cnt >= 1 && t_cnt <= 7) begin
               tgt_pull = !t_tx[7 - t_cnt];
            end
         end
      end else if (scl_bus && p_sda && !sda_bus) begin
         starts = starts + 1;  t_act = 1'b1;  t_cnt = 0;  t_bidx = 0;
         t_send = 1'b0;  t_pend = 1'b0;  tgt_pull = 1'b0;
      end else if (scl_bus && !p_sda && sda_bus) begin
         stops = stops + 1;  t_act = 1'b0;  t_send = 1'b0;  tgt_pull = 1'b0;
      end
      p_scl = scl_bus;
      p_sda = sda_bus;
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic launch(input logic rd, input logic [7:0] ra, input logic [7:0] wd);
      @(negedge clk);
      go = 1'b1;  rd_nwr = rd;  reg_addr = ra;  wr_data = wd;
      @(negedge clk);
      go = 1'b0;
      chk("R6 busy after go", busy, 1);
   endtask

   task automatic finish_txn(input logic exp_err);
      while (!done) @(negedge clk);
      chk("R6 busy low with done", busy, 0);
      chk("R5 nack_err with done", nack_err, exp_err);
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;  n_bad++;
      $display("FAIL R6 watchdog: actual hang expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 scl_oe", scl_oe, 0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 nack_err", nack_err, 0);
      chk("R1 lines idle", {scl_oe, sda_oe}, 0);

      for (int v = 0; v < NV; v++) begin
         logic rd;  logic [7:0] ra, wd, exp_rd;  int nk, base, s0, p0, ecnt, est;
         rd = VEC[v][19];  ra = VEC[v][18:11];  wd = VEC[v][10:3];  nk = int'(VEC[v][2:0]);
         exp_rd = smem[ra];
         base = t_n;  s0 = starts;  p0 = stops;
         nack_abs = (nk == NONE) ? -1 : base + nk;
         launch(rd, ra, wd);
         finish_txn(nk != NONE);
         ecnt = (nk == NONE) ? 3 : nk + 1;
         est  = (rd && (nk == NONE || nk >= 2)) ? 2 : 1;
         chk("R3/R4/R5 byte count", t_n - base, ecnt);
         chk("R2/R4 START count", starts - s0, est);
         chk("R2/R5 STOP count", stops - p0, 1);
         chk("R3 addr byte", tlog[base[7:0]], 8'hD0);
         if (ecnt >= 2) chk("R3 index byte", tlog[8'(base + 1)], ra);
         if (ecnt >= 3) chk("R3/R4 third byte", tlog[8'(base + 2)], rd ? 8'hD1 : wd);
         if (!rd && nk == NONE) smem[ra] = wd;
         if (rd && nk == NONE) begin
            chk("R4 rd_data", rd_data, exp_rd);
            chk("R4 master NACK", t_mack, 1);
         end
         if (v == 0) chk("R2 SCL period", rise_last - rise_prev, 4 * QC);
      end

      // R7: go pulsed mid-transfer with a different command
      begin
         int base, s0;
         base = t_n;  s0 = starts;  nack_abs = -1;
         launch(1'b0, 8'h50, 8'h11);
         repeat (40) @(negedge clk);
         go = 1'b1;  rd_nwr = 1'b1;  reg_addr = 8'h60;  wr_data = 8'h22;
         @(negedge clk);
         go = 1'b0;
         finish_txn(1'b0);
         smem[8'h50] = 8'h11;
         repeat (200) @(negedge clk);
         chk("R7 no second txn busy", busy, 0);
         chk("R7 one START", starts - s0, 1);
         chk("R7 byte count", t_n - base, 3);
         chk("R7 index kept", tlog[8'(base + 1)], 8'h50);
         chk("R7 data kept", tlog[8'(base + 2)], 8'h11);
         chk("R7 stored", tmem[8'h50], 8'h11);
      end

      // R5: error flag cleared by next accepted go
      nack_abs = t_n;
      launch(1'b0, 8'h70, 8'h01);
      finish_txn(1'b1);
      nack_abs = -1;
      launch(1'b1, 8'h50, 8'h00);
      chk("R5 err cleared at go", nack_err, 0);
      finish_txn(1'b0);
      chk("R4 read back", rd_data, 8'h11);
      chk("R5 unwritten kept", tmem[8'h70], smem[8'h70]);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule